// File: doc/BRIEF.md
# Multiplexed System Bus Address/Data Interface

This block joins a processor's local address and data lines to a 24-bit multiplexed system bus. In the address phase it places an address word on the shared lines. The address comes from one of two sources. The first is a 16-bit physical page address from an external translation unit, joined to the low offset byte. The second is the raw 16-bit logical offset joined to a 7-bit segment number.

In the data phase the address drivers go off. The write/read line, the active-low data strobe and the bus acknowledge then decide the data drivers. A write sends the CPU word toward the bus. A read captures the bus word for the CPU. For a byte read at an even address, the byte-swap path replaces the normal buffers. It moves bus byte 0-7 onto CPU bits 8-15.

All outputs are registered one clock after the inputs that cause them. The tristate drivers appear as separate enable outputs.

Top module: `mux_bus_iface`

## Requirements
- R1: After reset, both driver enables are 0, the bus output word is 0, the read-valid flag is 0 and the read data is 0.
- R2: A cycle with addr_phase=1 and ds_n=1 enables the address drivers on the next cycle. If xlat_valid=1, the bus word has xlat_addr on bits 23:8 and log_off[7:0] on bits 7:0.
- R3: In the same kind of cycle with xlat_valid=0, the bus word has 0 on bit 23, seg_num on bits 22:16 and log_off on bits 15:0.
- R4: Any cycle with ds_n=0 turns the address drivers off on the next cycle, even when addr_phase is still 1.
- R5: A cycle with wr_rd=1, ds_n=0 and bus_ack=1 turns on the data drivers on the next cycle. The bus word then carries cpu_wdata on bits 15:0 and 0 on bits 23:16.
- R6: With bus_ack=0, the next cycle has the data drivers off and no read capture, and the read data is unchanged. If no driver is enabled, the bus output word is 0.
- R7: A word read (wr_rd=0, ds_n=0, bus_ack=1, with byte_op=0 latched in the address phase) returns bus_ad_in[15:0] on cpu_rdata. rd_valid is high for one cycle.
- R8: A byte read whose latched address bit 0 is 0 returns bus_ad_in[7:0] on cpu_rdata[15:8] and 0 on cpu_rdata[7:0].
- R9: A byte read whose latched address bit 0 is 1 passes bus_ad_in[15:0] through unchanged.
- R10: cpu_rdata holds its value in every cycle without a read capture, and rd_valid is 0 in those cycles.
- R11: The choice between swap and straight-through uses log_off[0] and byte_op as latched in the last address-phase cycle. It does not use their values during the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_phase | input | 1 | Address phase in progress; also latches bit 0 and byte_op |
| xlat_valid | input | 1 | Translated physical address is valid |
| xlat_addr | input | 16 | Translated physical address bits for bus 23:8 |
| log_off | input | 16 | Logical offset |
| seg_num | input | 7 | Segment number |
| byte_op | input | 1 | Transfer is a byte |
| wr_rd | input | 1 | 1 = write, 0 = read |
| ds_n | input | 1 | Data strobe, active low |
| bus_ack | input | 1 | Bus granted to this interface |
| cpu_wdata | input | 16 | CPU write data |
| bus_ad_in | input | 24 | Value sampled from the bus lines |
| bus_ad_out | output | 24 | Value driven toward the bus lines |
| bus_addr_oe | output | 1 | Address drivers enabled |
| bus_data_oe | output | 1 | Data drivers enabled toward the bus |
| cpu_rdata | output | 16 | Captured read data for the CPU |
| rd_valid | output | 1 | One-cycle pulse when cpu_rdata was just captured |

## Verification
The hardest case to reach is a swapped byte read where the offset lines during the strobe no longer match the address that was latched. In a plain test the two agree, so the latch is never tested. The stimulus therefore latches an even byte address and then presents an odd offset during the read, which must still swap. It also does the reverse, which must not swap. Reads and writes without acknowledge are placed between captures, so that a read data value that is wrongly held or wrongly changed shows up.

// File: rtl/mbi_pkg.sv
package mbi_pkg;
    typedef enum logic [1:0] {
        DRV_NONE = 2'd0,
        DRV_ADDR = 2'd1,
        DRV_DATA = 2'd2
    } drv_e;
endpackage

// File: rtl/mbi_addr_mux.sv
module mbi_addr_mux #(
    parameter int BUS_W = 24,
    parameter int OFF_W = 16,
    parameter int XL_W  = 16,
    parameter int SEG_W = 7
) (
    input  logic             xlat_valid,
    input  logic [XL_W-1:0]  xlat_addr,
    input  logic [OFF_W-1:0] log_off,
    input  logic [SEG_W-1:0] seg_num,
    output logic [BUS_W-1:0] addr_word
);
    localparam int LOW_W = BUS_W - XL_W;
    localparam int PAD_W = BUS_W - OFF_W - SEG_W;

    logic [BUS_W-1:0] xl_word;
    logic [BUS_W-1:0] raw_word;

    assign xl_word = {xlat_addr, log_off[LOW_W-1:0]};

    generate
        if (PAD_W > 0) begin : g_pad
            assign raw_word = {{PAD_W{1'b0}}, seg_num, log_off};
        end else begin : g_nopad
            assign raw_word = {seg_num, log_off};
        end
    endgenerate

    always_comb begin
        addr_word = xlat_valid ? xl_word : raw_word;
    end
endmodule

// File: rtl/mbi_strobe_decode.sv
module mbi_strobe_decode
    import mbi_pkg::*;
(
    input  logic addr_phase,
    input  logic wr_rd,
    input  logic ds_n,
    input  logic bus_ack,
    output drv_e drv,
    output logic rd_en
);
    always_comb begin
        drv   = DRV_NONE;
        rd_en = 1'b0;
        if (ds_n) begin
            if (addr_phase) drv = DRV_ADDR;
        end else if (bus_ack) begin
            if (wr_rd) drv = DRV_DATA;
            else       rd_en = 1'b1;
        end
    end
endmodule

// File: rtl/mbi_rd_steer.sv
module mbi_rd_steer #(
    parameter int BUS_W = 24,
    parameter int DAT_W = 16
) (
    input  logic [BUS_W-1:0] bus_in,
    input  logic             swap,
    output logic [DAT_W-1:0] cpu_word
);
    localparam int HALF = DAT_W / 2;

    always_comb begin
        if (swap) cpu_word = {bus_in[HALF-1:0], {HALF{1'b0}}};
        else      cpu_word = bus_in[DAT_W-1:0];
    end
endmodule

// File: rtl/mux_bus_iface.sv
module mux_bus_iface
    import mbi_pkg::*;
#(
    parameter int BUS_W = 24,
    parameter int OFF_W = 16,
    parameter int XL_W  = 16,
    parameter int SEG_W = 7,
    parameter int DAT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_phase,
    input  logic             xlat_valid,
    input  logic [XL_W-1:0]  xlat_addr,
    input  logic [OFF_W-1:0] log_off,
    input  logic [SEG_W-1:0] seg_num,
    input  logic             byte_op,
    input  logic             wr_rd,
    input  logic             ds_n,
    input  logic             bus_ack,
    input  logic [DAT_W-1:0] cpu_wdata,
    input  logic [BUS_W-1:0] bus_ad_in,
    output logic [BUS_W-1:0] bus_ad_out,
    output logic             bus_addr_oe,
    output logic             bus_data_oe,
    output logic [DAT_W-1:0] cpu_rdata,
    output logic             rd_valid
);
    localparam int HALF = DAT_W / 2;

    typedef struct packed {
        drv_e             drv;
        logic [BUS_W-1:0] ad_out;
        logic [DAT_W-1:0] rdata;
        logic             rd_valid;
        logic             a0;
        logic             byte_rd;
        logic             xlat;
        logic             swap;
    } state_t;

    state_t state_d, state_q;

    logic [BUS_W-1:0] addr_word;
    logic [DAT_W-1:0] steered;
    drv_e             drv_sel;
    logic             rd_en;
    logic             swap_now;
    logic [BUS_W-1:0] wr_word;

    mbi_addr_mux #(
        .BUS_W(BUS_W), .OFF_W(OFF_W), .XL_W(XL_W), .SEG_W(SEG_W)
    ) u_addr (
        .xlat_valid(xlat_valid),
        .xlat_addr (xlat_addr),
        .log_off   (log_off),
        .seg_num   (seg_num),
        .addr_word (addr_word)
    );

    mbi_strobe_decode u_dec (
        .addr_phase(addr_phase),
        .wr_rd     (wr_rd),
        .ds_n      (ds_n),
        .bus_ack   (bus_ack),
        .drv       (drv_sel),
        .rd_en     (rd_en)
    );

    assign swap_now = rd_en && state_q.byte_rd && !state_q.a0;

    mbi_rd_steer #(.BUS_W(BUS_W), .DAT_W(DAT_W)) u_steer (
        .bus_in  (bus_ad_in),
        .swap    (swap_now),
        .cpu_word(steered)
    );

    always_comb begin
        wr_word = '0;
        wr_word[DAT_W-1:0] = cpu_wdata;
    end

    always_comb begin
        state_d          = state_q;
        state_d.drv      = drv_sel;
        state_d.rd_valid = 1'b0;
        state_d.swap     = 1'b0;
        case (drv_sel)
            DRV_ADDR: state_d.ad_out = addr_word;
            DRV_DATA: state_d.ad_out = wr_word;
            default:  state_d.ad_out = '0;
        endcase
        if (addr_phase) begin
            state_d.a0      = log_off[0];
            state_d.byte_rd = byte_op;
            state_d.xlat    = xlat_valid;
        end
        if (rd_en) begin
            state_d.rdata    = steered;
            state_d.rd_valid = 1'b1;
            state_d.swap     = swap_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign bus_ad_out  = state_q.ad_out;
    assign bus_addr_oe = (state_q.drv == DRV_ADDR);
    assign bus_data_oe = (state_q.drv == DRV_DATA);
    assign cpu_rdata   = state_q.rdata;
    assign rd_valid    = state_q.rd_valid;

    p_drivers_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_addr_oe && bus_data_oe));

    p_strobe_kills_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_n |=> !bus_addr_oe);

    p_no_ack_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ack |=> (!bus_data_oe && !rd_valid));

    p_raw_top_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_oe && !state_q.xlat) |-> (bus_ad_out[BUS_W-1] == 1'b0));

    p_swap_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && state_q.swap) |->
            (cpu_rdata[DAT_W-1:HALF] == $past(bus_ad_in[HALF-1:0])
             && cpu_rdata[HALF-1:0] == '0));

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(cpu_rdata));
endmodule

// File: tb/mux_bus_iface_test.sv
`timescale 1ns/1ps
module mux_bus_iface_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_phase = 1'b0, xlat_valid = 1'b0, byte_op = 1'b0;
    logic        wr_rd = 1'b0, ds_n = 1'b1, bus_ack = 1'b0;
    logic [15:0] xlat_addr = '0, log_off = '0, cpu_wdata = '0;
    logic [6:0]  seg_num = '0;
    logic [23:0] bus_ad_in = '0;
    logic [23:0] bus_ad_out;
    logic        bus_addr_oe, bus_data_oe, rd_valid;
    logic [15:0] cpu_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string       req;
        logic [23:0] ad;
        logic        aoe;
        logic        doe;
        logic [15:0] rd;
        logic        rv;
    } item_t;

    item_t sb[$];

    logic        m_a0 = 1'b0, m_byte = 1'b0;
    logic [15:0] m_rdata = '0;

    always #4 clk = ~clk;

    mux_bus_iface uut (
        .clk(clk), .rst_n(rst_n), .addr_phase(addr_phase), .xlat_valid(xlat_valid),
        .xlat_addr(xlat_addr), .log_off(log_off), .seg_num(seg_num), .byte_op(byte_op),
        .wr_rd(wr_rd), .ds_n(ds_n), .bus_ack(bus_ack), .cpu_wdata(cpu_wdata),
        .bus_ad_in(bus_ad_in), .bus_ad_out(bus_ad_out), .bus_addr_oe(bus_addr_oe),
        .bus_data_oe(bus_data_oe), .cpu_rdata(cpu_rdata), .rd_valid(rd_valid)
    );

    task automatic apply(input string req, input logic ap, input logic xv,
                         input logic [15:0] xa, input logic [15:0] off,
                         input logic [6:0] seg, input logic [15:0] wd,
                         input logic wr, input logic dsn, input logic ack,
                         input logic bo, input logic [23:0] bin);
        item_t it;
        logic  adrv, wdrv, rd;
        @(negedge clk);
        addr_phase = ap; xlat_valid = xv; xlat_addr = xa; log_off = off;
        seg_num = seg; cpu_wdata = wd; wr_rd = wr; ds_n = dsn; bus_ack = ack;
        byte_op = bo; bus_ad_in = bin;
        adrv = ap && dsn;
        wdrv = !dsn && ack && wr;
        rd   = !dsn && ack && !wr;
        it.req = req;
        it.aoe = adrv;
        it.doe = wdrv;
        it.rv  = rd;
        if (adrv)      it.ad = xv ? {xa, off[7:0]} : {1'b0, seg, off};
        else if (wdrv) it.ad = {8'h00, wd};
        else           it.ad = 24'h0;
        if (rd) begin
            if (m_byte && !m_a0) m_rdata = {bin[7:0], 8'h00};
            else                 m_rdata = bin[15:0];
        end
        it.rd = m_rdata;
        if (ap) begin
            m_a0 = off[0];
            m_byte = bo;
        end
        sb.push_back(it);
    endtask

    initial begin : monitor
        item_t e;
        bit    bad;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                checks++;
                bad = 1'b0;
                if (bus_ad_out !== e.ad) begin
                    bad = 1'b1;
                    $display("FAIL %s bus_ad_out act %h exp %h", e.req, bus_ad_out, e.ad);
                end
                if (bus_addr_oe !== e.aoe || bus_data_oe !== e.doe) begin
                    bad = 1'b1;
                    $display("FAIL %s oe act %b%b exp %b%b", e.req,
                             bus_addr_oe, bus_data_oe, e.aoe, e.doe);
                end
                if (cpu_rdata !== e.rd || rd_valid !== e.rv) begin
                    bad = 1'b1;
                    $display("FAIL %s rdata/valid act %h/%b exp %h/%b", e.req,
                             cpu_rdata, rd_valid, e.rd, e.rv);
                end
                if (bad) errors++;
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        checks++;
        if (bus_ad_out !== 24'h0 || bus_addr_oe !== 1'b0 || bus_data_oe !== 1'b0
            || cpu_rdata !== 16'h0 || rd_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset act %h %b%b %h %b exp 0", bus_ad_out,
                     bus_addr_oe, bus_data_oe, cpu_rdata, rd_valid);
        end
        rst_n = 1'b1;

        // R2 translated address
        apply("R2", 1, 1, 16'hA5C3, 16'h1234, 7'h11, 16'h0, 0, 1, 0, 0, 24'h0);
        // R3 untranslated, bit 23 held low even with all ones
        apply("R3", 1, 0, 16'hFFFF, 16'hBEEF, 7'h55, 16'h0, 0, 1, 0, 0, 24'h0);
        apply("R3", 1, 0, 16'hFFFF, 16'hFFFF, 7'h7F, 16'h0, 0, 1, 0, 0, 24'h0);
        // R4 strobe while addr_phase still high; R5 write
        apply("R4", 1, 1, 16'h1111, 16'h2222, 7'h0, 16'hCAFE, 1, 0, 1, 0, 24'h0);
        apply("R5", 0, 0, 16'h0, 16'h0, 7'h0, 16'h1357, 1, 0, 1, 0, 24'hFFFFFF);
        // R6 no acknowledge: write and read
        apply("R6", 0, 0, 16'h0, 16'h0, 7'h0, 16'hCAFE, 1, 0, 0, 0, 24'h0);
        apply("R6", 0, 0, 16'h0, 16'h0, 7'h0, 16'h0, 0, 0, 0, 0, 24'h00ABCD);
        // R7 word read
        apply("R7", 1, 0, 16'h0, 16'h0040, 7'h2, 16'h0, 0, 1, 0, 0, 24'h0);
        apply("R7", 0, 0, 16'h0, 16'h0040, 7'h2, 16'h0, 0, 0, 1, 0, 24'h123456);
        // R10 idle and unacknowledged read hold data
        apply("R10", 0, 0, 16'h0, 16'h0, 7'h0, 16'h0, 0, 1, 1, 0, 24'h999999);
        apply("R10", 0, 0, 16'h0, 16'h0, 7'h0, 16'h0, 0, 0, 0, 0, 24'h777777);
        // R8 even byte read, with R11 odd offset on lines during strobe
        apply("R8", 1, 0, 16'h0, 16'h0100, 7'h3, 16'h0, 0, 1, 0, 1, 24'h0);
        apply("R11", 0, 0, 16'h0, 16'h0101, 7'h3, 16'h0, 0, 0, 1, 0, 24'h0077AB);
        // R9 odd byte read
        apply("R9", 1, 0, 16'h0, 16'h0103, 7'h3, 16'h0, 0, 1, 0, 1, 24'h0);
        apply("R9", 0, 0, 16'h0, 16'h0103, 7'h3, 16'h0, 0, 0, 1, 1, 24'h009C5D);
        // R11 odd byte latched, even offset on lines: no swap
        apply("R11", 1, 1, 16'h4000, 16'h0205, 7'h0, 16'h0, 0, 1, 0, 1, 24'h0);
        apply("R11", 0, 0, 16'h0, 16'h0204, 7'h0, 16'h0, 0, 0, 1, 1, 24'h00E13C);
        // R8 second even byte read through translated address
        apply("R8", 1, 1, 16'h8001, 16'h0306, 7'h0, 16'h0, 0, 1, 0, 1, 24'h0);
        apply("R8", 0, 0, 16'h0, 16'h0306, 7'h0, 16'h0, 0, 0, 1, 1, 24'hFF42FE);
        apply("R10", 0, 0, 16'h0, 16'h0, 7'h0, 16'h0, 0, 1, 0, 0, 24'h0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule